// File: doc/BRIEF.md
# Serial Display Controller Host Interface

This block is the host-facing serial port of a segment display controller. A host drives a chip-select (active low), a write strobe, a read strobe and a data line that the block can also drive. Every transfer opens with a 3-bit mode code clocked in on write-strobe rising edges. The code picks one of three kinds of transfer. A read streams 4-bit words out of display memory. A write streams words into it, and in the same mode a read-modify-write alternates the two phases. A command transfer carries one or more 9-bit configuration words. All host pins are brought into the system clock through a synchronizer, and every edge is detected there.

Memory transfers carry a 6-bit start address, sent most significant bit first. After it come 4-bit words, sent least significant bit first. The address moves forward by one after each word and wraps from 63 to 0. The block drives a 64 x 4 memory port: a write address, write data and a one-cycle write enable, with read data returned combinationally. Command words update configuration registers: system enable, display enable, bias choice, common count, interrupt enable and rate select. Each command word also raises a one-cycle strobe that presents the full word.

States: IDLE (chip-select high), ID (collecting the mode code), HALT (unknown code, ignore until deselected), ADDR (collecting the address), RDAT (read stream), WDAT (write stream, or waiting for the read half of a read-modify-write), RMWR (read half), RMWW (write half), CMD (command words). Transitions: any state to IDLE on deselect; IDLE to ID on select; ID to ADDR on codes 110 or 101, to CMD on 100, to HALT otherwise; ADDR to RDAT (code 110) or WDAT (code 101) after the sixth address bit; WDAT to RMWR on a read-strobe fall at a word boundary; RMWR to RMWW on the first write-strobe rise after four bits have been read; RMWW to WDAT after the fourth written bit.

Top module: `lcd_serial_if`

## Requirements
- R1: While sel_n is high the interface returns to IDLE and a partly sent word is discarded, so no memory write takes place. After sel_n goes low, a new mode code must be sent.
- R2: Mode codes are 3'b110 read, 3'b101 write / read-modify-write and 3'b100 command, first bit sent as the MSB. Any other code makes the rest of the transfer have no effect on memory or configuration.
- R3: In a write, 6 address bits (MSB first) and then 4 data bits (bit 0 first) are taken on write-strobe rising edges. After the fourth bit, mem_we pulses for exactly one cycle with mem_addr and mem_wdata holding that word.
- R4: Further words in the same write go to consecutive addresses without resending the address, and the address wraps from 63 to 0.
- R5: In a read, each read-strobe falling edge drives the next bit of the current word on sd_out, bit 0 first. After four bits the address advances by one, wrapping from 63 to 0.
- R6: In write mode, a read-strobe fall at a word boundary starts a read-modify-write. Four bits of the current word are read out, then four new bits are written to the same address, and the address then advances.
- R7: A command is 9 bits sent MSB first (bit 8 first). Each completed word pulses cmd_stb for one cycle with cmd_word holding the word. Further words follow with no new mode code.
- R8: Command 9'b0000_0001_x sets sys_on. 9'b0000_0000_x clears both sys_on and disp_on. 9'b0000_0011_x sets disp_on and 9'b0000_0010_x clears it.
- R9: Command 9'b0010_ab_x_c_x loads com_sel with {a,b} (bits 4:3) and bias_third with c (bit 1).
- R10: Command 9'b100x_e_xxxx loads irq_en with e (bit 4). Command 9'b101x_0_fff_x loads rate_sel with fff (bits 3:1).
- R11: sd_oe is high only in the read phases (RDAT, RMWR). It is low one cycle after a synchronized deselect.
- R12: Strobes in the wrong phase are ignored. This covers a write-strobe rise during a read stream and a read-strobe fall in the middle of a written word. Neither changes memory, the address or the word being assembled.
- R13: After reset, sd_oe, mem_we and cmd_stb are 0. sys_on, disp_on, bias_third, irq_en are 0, and com_sel and rate_sel are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Host chip-select, active low |
| wr_strb | input | 1 | Host write strobe, bits taken on rising edge |
| rd_strb | input | 1 | Host read strobe, bits driven after falling edge |
| sd_in | input | 1 | Serial data from host |
| sd_out | output | 1 | Serial data to host |
| sd_oe | output | 1 | Drive enable for the shared data line |
| mem_addr | output | ADDR_W | Display memory address |
| mem_wdata | output | DATA_W | Display memory write data |
| mem_we | output | 1 | Display memory write enable, one cycle |
| mem_rdata | input | DATA_W | Display memory read data at mem_addr |
| cmd_stb | output | 1 | One-cycle pulse per completed command word |
| cmd_word | output | 9 | Last completed command word |
| sys_on | output | 1 | System enable |
| disp_on | output | 1 | Display enable |
| bias_third | output | 1 | 1 selects third bias, 0 half bias |
| com_sel | output | 2 | Common-count selection |
| irq_en | output | 1 | Interrupt output enable |
| rate_sel | output | 3 | Rate selection |

## Verification
A strobe edge passes two synchronizer stages and one edge register, so its effect reaches the state or sd_out on the third system clock after the pin changes. A write enable then shows up one cycle after the fourth bit is taken, and a configuration register one cycle after cmd_stb. The bench holds each strobe level for six clock periods and samples outputs at a falling clock edge at the end of that level, which is after every result is due. A scoreboard queue holds each expected address/data write, and a monitor compares every mem_we pulse against the queue at falling clock edges, so any early, extra or missing write is seen in the cycle it occurs.

// File: rtl/lcd_serial_if_pkg.sv
package lcd_serial_if_pkg;

    localparam int CMD_W = 9;
    localparam int ID_W  = 3;

    localparam logic [ID_W-1:0] MODE_READ  = 3'b110;
    localparam logic [ID_W-1:0] MODE_WRITE = 3'b101;
    localparam logic [ID_W-1:0] MODE_CMD   = 3'b100;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_HALT,
        ST_ADDR,
        ST_RDAT,
        ST_WDAT,
        ST_RMWR,
        ST_RMWW,
        ST_CMD
    } lif_state_e;

endpackage

// File: rtl/lif_sync.sv
module lif_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= RST_VAL;
            else        stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lif_cmd_regs.sv
module lif_cmd_regs
    import lcd_serial_if_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic [CMD_W-1:0] word,
    output logic             sys_on,
    output logic             disp_on,
    output logic             bias_third,
    output logic [1:0]       com_sel,
    output logic             irq_en,
    output logic [2:0]       rate_sel
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_on     <= 1'b0;
            disp_on    <= 1'b0;
            bias_third <= 1'b0;
            com_sel    <= 2'b00;
            irq_en     <= 1'b0;
            rate_sel   <= 3'b000;
        end else if (stb) begin
            if (word[8:5] == 4'b0000) begin
                case (word[4:1])
                    4'h0: begin sys_on <= 1'b0; disp_on <= 1'b0; end
                    4'h1: sys_on  <= 1'b1;
                    4'h2: disp_on <= 1'b0;
                    4'h3: disp_on <= 1'b1;
                    default: ;
                endcase
            end else if (word[8:5] == 4'b0010) begin
                com_sel    <= word[4:3];
                bias_third <= word[1];
            end else if (word[8:6] == 3'b100) begin
                irq_en <= word[4];
            end else if (word[8:6] == 3'b101 && !word[4]) begin
                rate_sel <= word[3:1];
            end
        end
    end

    // R8
    sysoff_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && word[8:1] == 8'h00) |=> (!sys_on && !disp_on));

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && word[8:6] == 3'b100) |=> (irq_en == $past(word[4])));
endmodule

// File: rtl/lcd_serial_if.sv
module lcd_serial_if
    import lcd_serial_if_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 4,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_strb,
    input  logic              rd_strb,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              sd_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cmd_stb,
    output logic [CMD_W-1:0]  cmd_word,
    output logic              sys_on,
    output logic              disp_on,
    output logic              bias_third,
    output logic [1:0]        com_sel,
    output logic              irq_en,
    output logic [2:0]        rate_sel
);
    localparam int MAXB   = (ADDR_W > CMD_W) ? ADDR_W : CMD_W;
    localparam int CNT_W  = $clog2(MAXB + 1);
    localparam int DIDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] ID_LAST   = CNT_W'(ID_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] DATA_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);

    logic s_sel, s_wr, s_rd, s_dat;
    logic wr_q, rd_q;
    logic wr_rise, rd_fall;

    lif_sync #(.W(4), .STAGES(SYNC_N), .RST_VAL(4'b1110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sel_n, wr_strb, rd_strb, sd_in}),
        .q     ({s_sel, s_wr, s_rd, s_dat})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= s_wr;
            rd_q <= s_rd;
        end
    end

    assign wr_rise = s_wr & ~wr_q;
    assign rd_fall = ~s_rd & rd_q;

    lif_state_e           state, nxt;
    logic [CNT_W-1:0]     cnt;
    logic [ID_W-1:0]      id_sh;
    logic [ID_W-1:0]      id_now;
    logic                 rd_mode;
    logic [ADDR_W-1:0]    addr;
    logic [DATA_W-1:0]    wbuf;
    logic [DATA_W-1:0]    wdata_q;
    logic                 we_q;
    logic [CMD_W-1:0]     csh;
    logic [CMD_W-1:0]     cmd_q;
    logic                 stb_q;
    logic                 dout;
    logic [DIDX_W-1:0]    idx;

    assign id_now = {id_sh[ID_W-2:0], s_dat};
    assign idx    = cnt[DIDX_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (s_sel) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_ID;
                ST_ID: if (wr_rise && cnt == ID_LAST) begin
                    if (id_now == MODE_READ || id_now == MODE_WRITE) nxt = ST_ADDR;
                    else if (id_now == MODE_CMD)                     nxt = ST_CMD;
                    else                                             nxt = ST_HALT;
                end
                ST_ADDR: if (wr_rise && cnt == ADDR_LAST)
                    nxt = rd_mode ? ST_RDAT : ST_WDAT;
                ST_WDAT: if (rd_fall && cnt == '0) nxt = ST_RMWR;
                ST_RMWR: if (wr_rise && cnt == DATA_FULL) nxt = ST_RMWW;
                ST_RMWW: if (wr_rise && cnt == DATA_LAST) nxt = ST_WDAT;
                ST_RDAT, ST_CMD, ST_HALT: nxt = state;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            id_sh   <= '0;
            rd_mode <= 1'b0;
            addr    <= '0;
            wbuf    <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            csh     <= '0;
            cmd_q   <= '0;
            stb_q   <= 1'b0;
            dout    <= 1'b0;
        end else begin
            we_q  <= 1'b0;
            stb_q <= 1'b0;
            if (we_q) addr <= addr + 1'b1;
            if (s_sel) begin
                cnt <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: cnt <= '0;
                    ST_ID: if (wr_rise) begin
                        id_sh   <= id_now;
                        rd_mode <= (id_now == MODE_READ);
                        cnt     <= (cnt == ID_LAST) ? '0 : cnt + 1'b1;
                    end
                    ST_ADDR: if (wr_rise) begin
                        addr <= {addr[ADDR_W-2:0], s_dat};
                        cnt  <= (cnt == ADDR_LAST) ? '0 : cnt + 1'b1;
                    end
                    ST_RDAT: if (rd_fall) begin
                        dout <= mem_rdata[idx];
                        if (cnt == DATA_LAST) begin
                            cnt  <= '0;
                            addr <= addr + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_WDAT, ST_RMWW: begin
                        if (wr_rise) begin
                            wbuf[idx] <= s_dat;
                            if (cnt == DATA_LAST) begin
                                we_q    <= 1'b1;
                                wdata_q <= {s_dat, wbuf[DATA_W-2:0]};
                                cnt     <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end else if (rd_fall && cnt == '0 && state == ST_WDAT) begin
                            dout <= mem_rdata[0];
                            cnt  <= CNT_W'(1);
                        end
                    end
                    ST_RMWR: begin
                        if (rd_fall && cnt != DATA_FULL) begin
                            dout <= mem_rdata[idx];
                            cnt  <= cnt + 1'b1;
                        end else if (wr_rise && cnt == DATA_FULL) begin
                            wbuf[0] <= s_dat;
                            cnt     <= CNT_W'(1);
                        end
                    end
                    ST_CMD: if (wr_rise) begin
                        csh <= {csh[CMD_W-2:0], s_dat};
                        if (cnt == CMD_LAST) begin
                            stb_q <= 1'b1;
                            cmd_q <= {csh[CMD_W-2:0], s_dat};
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_HALT: ;
                    default: cnt <= '0;
                endcase
            end
        end
    end

    assign sd_out    = dout;
    assign sd_oe     = (state == ST_RDAT) || (state == ST_RMWR);
    assign mem_addr  = addr;
    assign mem_wdata = wdata_q;
    assign mem_we    = we_q;
    assign cmd_stb   = stb_q;
    assign cmd_word  = cmd_q;

    lif_cmd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (stb_q),
        .word       (cmd_q),
        .sys_on     (sys_on),
        .disp_on    (disp_on),
        .bias_third (bias_third),
        .com_sel    (com_sel),
        .irq_en     (irq_en),
        .rate_sel   (rate_sel)
    );

    // R11
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_sel |=> !sd_oe);

    // R3
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R4
    addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R7
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);

    // R12
    no_write_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDAT && $past(state) == ST_RDAT) |-> !mem_we);
endmodule

// File: tb/lcd_serial_if_tb_top.sv
module lcd_serial_if_tb_top;
    localparam int CLK_P = 10;
    localparam int HOLD  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, wr_strb = 1'b1, rd_strb = 1'b1, sd_in = 1'b0;
    logic sd_out, sd_oe, mem_we, cmd_stb;
    logic [5:0] mem_addr;
    logic [3:0] mem_wdata, mem_rdata;
    logic [8:0] cmd_word;
    logic sys_on, disp_on, bias_third, irq_en;
    logic [1:0] com_sel;
    logic [2:0] rate_sel;

    always #(CLK_P/2) clk = ~clk;

    lcd_serial_if dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_strb(wr_strb),
        .rd_strb(rd_strb), .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .cmd_stb(cmd_stb), .cmd_word(cmd_word),
        .sys_on(sys_on), .disp_on(disp_on), .bias_third(bias_third),
        .com_sel(com_sel), .irq_en(irq_en), .rate_sel(rate_sel)
    );

    // display memory outside the block
    logic [3:0] mem_model [64];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem_model[i] <= 4'h0;
        end else if (mem_we) begin
            mem_model[mem_addr] <= mem_wdata;
        end
    end
    assign mem_rdata = mem_model[mem_addr];

    int vectors = 0;
    int miscompares = 0;
    int stb_seen = 0;
    bit done = 1'b0;
    logic [9:0] wq [$];
    logic [3:0] exp_mem [64];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor for memory writes (R3, R4, R6)
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            vectors++;
            if (wq.size() == 0) begin
                miscompares++;
                $display("FAIL R3 unexpected write actual=%0h expected=none", {mem_addr, mem_wdata});
            end else begin
                automatic logic [9:0] e = wq.pop_front();
                if ({mem_addr, mem_wdata} !== e) begin
                    miscompares++;
                    $display("FAIL R3 write actual=%0h expected=%0h", {mem_addr, mem_wdata}, e);
                end
            end
        end
        if (rst_n && cmd_stb) stb_seen++;
    end

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_xfer();
        sel_n = 1'b1; waitn(HOLD);
        sel_n = 1'b0; waitn(HOLD);
    endtask

    task automatic end_xfer();
        sel_n = 1'b1; waitn(HOLD);
    endtask

    task automatic wr_bit(input logic b);
        sd_in = b; wr_strb = 1'b0; waitn(HOLD);
        wr_strb = 1'b1; waitn(HOLD);
    endtask

    task automatic rd_bit(output logic b, output logic oe);
        rd_strb = 1'b0; waitn(HOLD);
        b = sd_out; oe = sd_oe;
        rd_strb = 1'b1; waitn(HOLD);
    endtask

    task automatic send_msb(input logic [8:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) wr_bit(v[i]);
    endtask

    task automatic send_word(input logic [5:0] a, input logic [3:0] d);
        wq.push_back({a, d});
        exp_mem[a] = d;
        for (int i = 0; i < 4; i++) wr_bit(d[i]);
    endtask

    task automatic read_word(input logic [5:0] a, input string req);
        logic [3:0] got;
        logic [3:0] oes;
        for (int i = 0; i < 4; i++) rd_bit(got[i], oes[i]);
        chk(got == exp_mem[a], req, got, exp_mem[a]);
        chk(oes == 4'hF, "R11 oe during read", oes, 4'hF);
    endtask

    initial begin
        logic b, oe;
        logic [5:0] a;
        for (int i = 0; i < 64; i++) exp_mem[i] = 4'h0;
        waitn(3);
        rst_n = 1'b1;
        waitn(3);

        // R13 reset state
        chk({sd_oe, mem_we, cmd_stb} == 3'b000, "R13 strobes", {sd_oe, mem_we, cmd_stb}, 0);
        chk({sys_on, disp_on, bias_third, com_sel, irq_en, rate_sel} == 9'h0, "R13 config",
            {sys_on, disp_on, bias_third, com_sel, irq_en, rate_sel}, 0);

        // R3 single write
        begin_xfer();
        send_msb(9'b101, 3); send_msb(9'd5, 6);
        send_word(6'd5, 4'hA);
        end_xfer();
        chk(sd_oe == 1'b0, "R11 idle oe", sd_oe, 0);

        // R4 burst write with wrap
        begin_xfer();
        send_msb(9'b101, 3); send_msb(9'd62, 6);
        send_word(6'd62, 4'h1); send_word(6'd63, 4'h2); send_word(6'd0, 4'h3);
        end_xfer();

        // R5 burst read with wrap
        begin_xfer();
        send_msb(9'b110, 3); send_msb(9'd62, 6);
        read_word(6'd62, "R5 read 62"); read_word(6'd63, "R5 read 63"); read_word(6'd0, "R5 read 0");
        end_xfer();
        chk(sd_oe == 1'b0, "R1 oe released after deselect", sd_oe, 0);

        // R6 read-modify-write burst
        begin_xfer();
        send_msb(9'b101, 3); send_msb(9'd5, 6);
        read_word(6'd5, "R6 rmw read 5"); send_word(6'd5, 4'h6);
        read_word(6'd6, "R6 rmw read 6"); send_word(6'd6, 4'h9);
        end_xfer();

        // R7..R10 chained commands
        begin_xfer();
        send_msb(9'b100, 3);
        send_msb(9'b0000_0001_0, 9);
        chk(sys_on == 1'b1, "R8 sys on", sys_on, 1);
        send_msb(9'b0000_0011_0, 9);
        chk(disp_on == 1'b1, "R8 disp on (chained, R7)", disp_on, 1);
        send_msb(9'b0010_1_0_0_1_0, 9);
        chk({com_sel, bias_third} == 3'b101, "R9 com/bias", {com_sel, bias_third}, 3'b101);
        send_msb(9'b100_0_1_0000, 9);
        chk(irq_en == 1'b1, "R10 irq enable", irq_en, 1);
        send_msb(9'b101_0_0_101_0, 9);
        chk(rate_sel == 3'd5, "R10 rate", rate_sel, 5);
        chk(cmd_word == 9'b101_0_0_101_0, "R7 cmd word", cmd_word, 9'b101_0_0_101_0);
        send_msb(9'b100_0_0_0000, 9);
        chk(irq_en == 1'b0, "R10 irq disable", irq_en, 0);
        send_msb(9'b0000_0000_0, 9);
        chk({sys_on, disp_on} == 2'b00, "R8 sys off", {sys_on, disp_on}, 0);
        end_xfer();
        chk(stb_seen == 7, "R7 strobe count", stb_seen, 7);

        // R1 abort mid-word, then read address back
        begin_xfer();
        send_msb(9'b101, 3); send_msb(9'd10, 6);
        wr_bit(1'b1); wr_bit(1'b1);
        end_xfer();
        begin_xfer();
        send_msb(9'b110, 3); send_msb(9'd10, 6);
        read_word(6'd10, "R1 aborted word not written");
        end_xfer();

        // R2 unknown mode code ignored
        begin_xfer();
        send_msb(9'b111, 3);
        send_msb(9'b0000_0001_0, 9);
        send_msb(9'b0000_0001_0, 9);
        chk({sys_on, stb_seen[3:0]} == 5'b0_0111, "R2 unknown code", {sys_on, stb_seen[3:0]}, 5'b0_0111);
        chk(sd_oe == 1'b0, "R2 no drive", sd_oe, 0);
        end_xfer();

        // R12 write strobes during read stream
        begin_xfer();
        send_msb(9'b110, 3); send_msb(9'd62, 6);
        wr_bit(1'b1); wr_bit(1'b0);
        read_word(6'd62, "R12 read after stray writes");
        end_xfer();

        // R12 read strobe in the middle of a written word
        begin_xfer();
        send_msb(9'b101, 3); send_msb(9'd20, 6);
        wq.push_back({6'd20, 4'hC});
        exp_mem[20] = 4'hC;
        wr_bit(1'b0); wr_bit(1'b0);
        rd_bit(b, oe);
        chk(oe == 1'b0, "R12 stray read no drive", oe, 0);
        wr_bit(1'b1); wr_bit(1'b1);
        end_xfer();
        a = 6'd20;
        begin_xfer();
        send_msb(9'b110, 3); send_msb({3'b000, a}, 6);
        read_word(a, "R12 word intact");
        end_xfer();

        waitn(4);
        chk(wq.size() == 0, "R3 all writes seen", wq.size(), 0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog (all R) actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule